// File: doc/BRIEF.md
# Coherent Split-Byte Counter Read

This block lets an 8-bit register bus read a free-running 16-bit counter without tearing. The counter is shown as two byte registers, a high byte and a low byte. The first byte read of a pair copies all 16 counter bits into a hold buffer. The matching read of the other byte then takes its half from that buffer, so the two bytes always come from the same count. Software may read the high byte first or the low byte first.

A debug-freeze input supports a halted processor. While it is high, reads return live counter bytes and leave the capture state and the buffer untouched. A coherent read that was half done before the freeze therefore completes correctly after it. A restart pulse returns the capture logic to idle, in or out of debug. Read data is registered and holds its value between reads.

This is a plain register-bus read port, so it has no valid/ready handshake. A strobe is accepted in the cycle it is high and never stalls. The data appears on `rd_data` in the next cycle.

Top module: `split_count_reader`

## Requirements
- R1: On reset (`rst_n` low) `rd_data` is 0 and no capture is pending. The first read after reset therefore returns a live counter byte and starts a new capture.
- R2: A read accepted with no capture pending (`rd_en`=1, `dbg_freeze`=0, `restart`=0) does two things. It sets `rd_data` in the next cycle to the selected byte of `cnt_in` as sampled in the strobe cycle. It also stores all 16 bits of `cnt_in` in the hold buffer. `rd_hi`=1 selects bits 15:8 and `rd_hi`=0 selects bits 7:0.
- R3: While a capture is pending, a read of the other byte returns that byte's half of the buffer and ends the capture. The read after that captures a fresh count.
- R4: While a capture is pending, a read of the byte that started it returns that byte's half of the buffer again. The capture stays pending.
- R5: A `restart` pulse returns the capture logic to idle, whether or not debug is active. A read in the same cycle as `restart` returns the live byte and does not start a capture.
- R6: While `dbg_freeze` is high, a read returns the selected live byte of `cnt_in` from the strobe cycle.
- R7: While `dbg_freeze` is high, reads change neither the capture state nor the buffer. A read in debug therefore never starts a capture.
- R8: When `dbg_freeze` falls while a capture is pending, the next read of the other byte returns the half stored before debug began.
- R9: In a cycle without `rd_en`, `rd_data` keeps its previous value even while `cnt_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Single-cycle pulse that returns the capture logic to idle |
| dbg_freeze | input | 1 | Debug mode: live reads, capture state frozen |
| cnt_in | input | 16 | Free-running counter value |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| rd_hi | input | 1 | Byte select: 1 high byte, 0 low byte |
| rd_data | output | 8 | Registered read data, valid the cycle after the strobe |

## Verification
The counter moves on every cycle of the bench, so live data and buffered data differ in both bytes. Each check therefore shows which source the design used.

Pairs are read high-first and low-first, with idle cycles between the two halves. These runs show that the capture state remembers which byte started it. A repeated read of the same byte separates "stays pending" from "releases".

Restart pulses are applied alone, together with a read, and inside debug. Debug reads are made both from a pending capture and from idle. Together these show the difference between bypassing the buffer and actually freezing the capture state.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    ARM_NONE  = 2'b00,
    ARM_BY_LO = 2'b01,
    ARM_BY_HI = 2'b10
  } arm_e;
endpackage

// File: rtl/scr_arm_fsm.sv
module scr_arm_fsm
  import scr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic dbg_freeze,
  input  logic rd_en,
  input  logic rd_hi,
  output arm_e arm_st,
  output logic capture,
  output logic use_buf
);
  arm_e arm_nx;
  logic live_rd;

  // A read that takes part in the coherent mechanism.
  assign live_rd = rd_en && !dbg_freeze && !restart;
  assign capture = live_rd && (arm_st == ARM_NONE);
  assign use_buf = live_rd && (arm_st != ARM_NONE);

  always_comb begin
    arm_nx = arm_st;
    if (restart) begin
      arm_nx = ARM_NONE;
    end else if (live_rd) begin
      unique case (arm_st)
        ARM_NONE:  arm_nx = rd_hi ? ARM_BY_HI : ARM_BY_LO;
        ARM_BY_HI: arm_nx = rd_hi ? ARM_BY_HI : ARM_NONE;
        ARM_BY_LO: arm_nx = rd_hi ? ARM_NONE : ARM_BY_LO;
        default:   arm_nx = ARM_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_st <= ARM_NONE;
    else        arm_st <= arm_nx;
  end
endmodule

// File: rtl/scr_hold_buf.sv
module scr_hold_buf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= cnt_in;
  end
endmodule

// File: rtl/scr_out_mux.sv
module scr_out_mux #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_hi,
  input  logic              use_buf,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [CNT_W-1:0]  hold_q,
  output logic [BYTE_W-1:0] rd_data
);
  logic [CNT_W-1:0]  src;
  logic [BYTE_W-1:0] lane [2];

  assign src = use_buf ? hold_q : cnt_in;

  for (genvar b = 0; b < 2; b++) begin : g_lane
    assign lane[b] = src[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_hi ? lane[1] : lane[0];
  end
endmodule

// File: rtl/split_count_reader.sv
module split_count_reader
  import scr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              dbg_freeze,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              rd_en,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data
);
  arm_e             arm_st;
  logic             capture;
  logic             use_buf;
  logic [CNT_W-1:0] hold_q;

  scr_arm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .dbg_freeze (dbg_freeze),
    .rd_en      (rd_en),
    .rd_hi      (rd_hi),
    .arm_st     (arm_st),
    .capture    (capture),
    .use_buf    (use_buf)
  );

  scr_hold_buf #(.CNT_W(CNT_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .cnt_in  (cnt_in),
    .hold_q  (hold_q)
  );

  scr_out_mux #(.BYTE_W(BYTE_W)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_hi   (rd_hi),
    .use_buf (use_buf),
    .cnt_in  (cnt_in),
    .hold_q  (hold_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              dbg_freeze,
  input logic [CNT_W-1:0]  cnt_in,
  input logic              rd_en,
  input logic              rd_hi,
  input logic [BYTE_W-1:0] rd_data,
  input logic [1:0]        arm_st,
  input logic [CNT_W-1:0]  hold_q
);
  logic normal_rd;
  logic other_rd;
  logic same_rd;

  assign normal_rd = rd_en && !dbg_freeze && !restart;
  assign other_rd  = normal_rd && ((arm_st == 2'b10 && !rd_hi) || (arm_st == 2'b01 && rd_hi));
  assign same_rd   = normal_rd && ((arm_st == 2'b10 && rd_hi) || (arm_st == 2'b01 && !rd_hi));

  // R2: idle read returns the live byte and arms
  a_r2_idle_read_live: assert property (@(posedge clk) disable iff (!rst_n)
    (normal_rd && arm_st == 2'b00) |=>
      (rd_data == ($past(rd_hi) ? $past(cnt_in[CNT_W-1:BYTE_W]) : $past(cnt_in[BYTE_W-1:0])))
      && (arm_st != 2'b00) && (hold_q == $past(cnt_in)));

  // R3: other-byte read comes from the buffer and releases
  a_r3_pair_release: assert property (@(posedge clk) disable iff (!rst_n)
    other_rd |=> (arm_st == 2'b00) &&
      (rd_data == ($past(rd_hi) ? $past(hold_q[CNT_W-1:BYTE_W]) : $past(hold_q[BYTE_W-1:0]))));

  // R4: same-byte read keeps the hold
  a_r4_same_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    same_rd |=> $stable(arm_st) && $stable(hold_q));

  // R5: restart idles the capture logic
  a_r5_restart_idles: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (arm_st == 2'b00));

  // R6: debug reads return live bytes
  a_r6_dbg_live: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && dbg_freeze) |=>
      (rd_data == ($past(rd_hi) ? $past(cnt_in[CNT_W-1:BYTE_W]) : $past(cnt_in[BYTE_W-1:0]))));

  // R7: debug freezes capture state and buffer
  a_r7_dbg_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_freeze && !restart) |=> $stable(arm_st) && $stable(hold_q));

  // R9: no strobe, no change on the read data
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind split_count_reader scr_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .restart    (restart),
  .dbg_freeze (dbg_freeze),
  .cnt_in     (cnt_in),
  .rd_en      (rd_en),
  .rd_hi      (rd_hi),
  .rd_data    (rd_data),
  .arm_st     (arm_st),
  .hold_q     (hold_q)
);

// File: tb/split_count_reader_test.sv
module split_count_reader_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        dbg_freeze = 1'b0;
  logic [15:0] cnt = 16'h1000;
  logic        rd_en = 1'b0;
  logic        rd_hi = 1'b0;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_count_reader uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .dbg_freeze (dbg_freeze),
    .cnt_in     (cnt),
    .rd_en      (rd_en),
    .rd_hi      (rd_hi),
    .rd_data    (rd_data)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected %02h", req, got, exp);
    end
  endtask

  // One clock: advance the counter, drive inputs at the falling edge,
  // return at the next falling edge, where rd_data is valid.
  task automatic cyc(input logic en, input logic hi, input logic rs, output logic [15:0] live);
    cnt     = cnt + 16'h0135;
    rd_en   = en;
    rd_hi   = hi;
    restart = rs;
    live    = cnt;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 reset value", rd_data, 8'h00);
    cyc(1'b1, 1'b0, 1'b0, v);
    chk("R1 first read live", rd_data, v[7:0]);
    cyc(1'b1, 1'b1, 1'b0, v);
  endtask

  task automatic t_hi_first();
    logic [15:0] v, w, x, y;
    cyc(1'b1, 1'b1, 1'b0, v);
    chk("R2 hi-first live byte", rd_data, v[15:8]);
    cyc(1'b0, 1'b0, 1'b0, w);
    cyc(1'b0, 1'b0, 1'b0, w);
    cyc(1'b1, 1'b0, 1'b0, w);
    chk("R3 lo from buffer", rd_data, v[7:0]);
    cyc(1'b1, 1'b0, 1'b0, x);
    chk("R3 fresh capture after release", rd_data, x[7:0]);
    cyc(1'b1, 1'b1, 1'b0, y);
    chk("R3 hi from lo-armed buffer", rd_data, x[15:8]);
  endtask

  task automatic t_lo_first();
    logic [15:0] v, w;
    cyc(1'b1, 1'b0, 1'b0, v);
    chk("R2 lo-first live byte", rd_data, v[7:0]);
    cyc(1'b0, 1'b1, 1'b0, w);
    cyc(1'b1, 1'b1, 1'b0, w);
    chk("R3 hi from buffer", rd_data, v[15:8]);
  endtask

  task automatic t_repeat();
    logic [15:0] v, w;
    cyc(1'b1, 1'b1, 1'b0, v);
    cyc(1'b1, 1'b1, 1'b0, w);
    chk("R4 repeated hi buffered", rd_data, v[15:8]);
    cyc(1'b1, 1'b0, 1'b0, w);
    chk("R4 hold kept for lo", rd_data, v[7:0]);
  endtask

  task automatic t_restart();
    logic [15:0] v, w, x;
    cyc(1'b1, 1'b1, 1'b0, v);
    cyc(1'b0, 1'b0, 1'b1, w);
    cyc(1'b1, 1'b0, 1'b0, w);
    chk("R5 read after restart live", rd_data, w[7:0]);
    cyc(1'b1, 1'b1, 1'b0, x);
    chk("R5 new capture completes", rd_data, w[15:8]);
    cyc(1'b1, 1'b1, 1'b0, v);
    cyc(1'b1, 1'b0, 1'b1, w);
    chk("R5 read with restart live", rd_data, w[7:0]);
    cyc(1'b1, 1'b0, 1'b0, x);
    chk("R5 restart read did not arm", rd_data, x[7:0]);
    cyc(1'b1, 1'b1, 1'b0, v);
    chk("R5 pair after restart", rd_data, x[15:8]);
  endtask

  task automatic t_debug();
    logic [15:0] v, w, x;
    cyc(1'b1, 1'b1, 1'b0, v);
    dbg_freeze = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, w);
    chk("R6 debug lo live", rd_data, w[7:0]);
    cyc(1'b1, 1'b1, 1'b0, w);
    chk("R6 debug hi live", rd_data, w[15:8]);
    dbg_freeze = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, x);
    chk("R8 half read completes", rd_data, v[7:0]);
    dbg_freeze = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, w);
    dbg_freeze = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, x);
    chk("R7 debug read did not arm", rd_data, x[7:0]);
    cyc(1'b1, 1'b1, 1'b0, w);
    chk("R7 capture after debug", rd_data, x[15:8]);
  endtask

  task automatic t_restart_in_dbg();
    logic [15:0] v, w;
    cyc(1'b1, 1'b1, 1'b0, v);
    dbg_freeze = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, w);
    cyc(1'b0, 1'b0, 1'b0, w);
    dbg_freeze = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, w);
    chk("R5 restart in debug idles", rd_data, w[7:0]);
    cyc(1'b1, 1'b1, 1'b0, v);
  endtask

  task automatic t_hold();
    logic [15:0] v, w;
    cyc(1'b1, 1'b0, 1'b0, v);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, w);
    chk("R9 data held without strobe", rd_data, v[7:0]);
    cyc(1'b1, 1'b1, 1'b0, w);
  endtask

  task automatic t_reset_mid();
    logic [15:0] v, w;
    cyc(1'b1, 1'b1, 1'b0, v);
    rst_n = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, w);
    chk("R1 reset clears data", rd_data, 8'h00);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, w);
    cyc(1'b1, 1'b0, 1'b0, w);
    chk("R1 reset dropped pending capture", rd_data, w[7:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hi_first();
    t_lo_first();
    t_repeat();
    t_restart();
    t_debug();
    t_restart_in_dbg();
    t_hold();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule